// File: doc/BRIEF.md
# Filter Coefficient and Control Register Loader

This block fills the parameter storage of a digital filter over one narrow path. Every transfer arrives as a string of 12-bit words on a shared bus. A falling edge on the active-low load strobe marks the first word, which is a header. The header's top three bits select a destination class, and the same class sets how many data words follow. Its low bits select an entry inside that class. The loader collects the data words, then commits them to storage in one clock edge. The storage holds eight coefficient banks, a small set of configuration words, and tables of select, round and limit registers.

A pause input lets the source stall at any point. While it is high, nothing is consumed and the sequencer keeps its position. Round and limit registers are 32 bits wide. Each is built from four words that carry one byte each, with the least significant byte first. Two combinational readback ports expose every stored value to the filter datapath, which lies outside this block.

Top module: `filt_cfg_loader`

## Requirements
- R1: In a header, bits 11:9 are the class code and bits 8:0 the address. Class codes are 000 coefficients, 001 configuration, 011 select, 101 round, 111 limit. Each transfer writes at most one class.
- R2: A header is taken only while the loader is idle and pause is low, on an edge where ld_n is low after it was high at the previous unpaused sample. If ld_n stays low, no further header is taken.
- R3: A coefficient header is followed by eight words. Word k goes to bank k at entry address[3:0].
- R4: A configuration or select header is followed by one word. Configuration entries are indexed by address[1:0] and select entries by address[3:0]. The whole 12-bit word is stored.
- R5: A round or limit header is followed by four words. The entry is indexed by address[3:0]. Word k supplies bits 8k+7:8k from its bits 7:0, and its bits 11:8 are ignored.
- R6: While pause is high, no header or data word is consumed. Input on din has no effect.
- R7: A header with code 010, 100 or 110 is consumed with zero data words and writes nothing. Words that follow are not headers unless a new strobe falling edge occurs.
- R8: After the last data word the loader is idle again. A new high-to-low strobe transition is needed for the next header.
- R9: Storage changes only on the edge that takes a transfer's last data word. Before that edge, readback shows the old value, and all bytes of a wide register change together.
- R10: Readback is combinational. reg_rd_cls uses the R1 codes 001, 011, 101 and 111, any other code reads zero, and narrow values are zero-extended.
- R11: Reset clears all stored values to zero and leaves the loader idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_n | input | 1 | Load strobe; high-to-low marks a header word |
| pause | input | 1 | Stall; high freezes the loader |
| din | input | 12 | Word bus for headers and data |
| coef_rd_bank | input | 3 | Coefficient readback bank |
| coef_rd_addr | input | 4 | Coefficient readback entry |
| coef_rd_data | output | 12 | Coefficient readback value |
| reg_rd_cls | input | 3 | Register readback class code |
| reg_rd_idx | input | 4 | Register readback index |
| reg_rd_data | output | 32 | Register readback value, zero-extended |

## Verification
The header is captured on the first rising edge with ld_n low and pause low, after a high sample. Each data word is taken on a later edge where pause is low. The commit happens on the edge that takes the last word, so storage is written zero cycles after that word. Readback is combinational, so a value is visible in the same cycle it is committed. The bench drives inputs at falling edges and reads back one nanosecond after a falling edge. This places every read at least half a cycle after the commit edge. The round-register test reads just before the final word and again just after it, so a partial update would show.

// File: rtl/filt_ld_pkg.sv
package filt_ld_pkg;

  localparam int WORD_W = 12;
  localparam int CLS_W  = 3;
  localparam int NSLOT  = 8;

  localparam logic [CLS_W-1:0] CLS_COEF = 3'b000;
  localparam logic [CLS_W-1:0] CLS_CFG  = 3'b001;
  localparam logic [CLS_W-1:0] CLS_SEL  = 3'b011;
  localparam logic [CLS_W-1:0] CLS_RND  = 3'b101;
  localparam logic [CLS_W-1:0] CLS_LIM  = 3'b111;

  typedef enum logic {ST_IDLE, ST_DATA} seq_st_e;

  // number of data words that follow a header of the given class
  function automatic logic [3:0] words_for(input logic [CLS_W-1:0] c);
    case (c)
      CLS_COEF:         words_for = 4'd8;
      CLS_CFG, CLS_SEL: words_for = 4'd1;
      CLS_RND, CLS_LIM: words_for = 4'd4;
      default:          words_for = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/filt_ld_seq.sv
module filt_ld_seq
  import filt_ld_pkg::*;
#(
  parameter int KEEP_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_n,
  input  logic                          pause,
  input  logic [WORD_W-1:0]             din,
  output logic                          busy,
  output logic                          hdr_take,
  output logic                          commit,
  output logic [CLS_W-1:0]              cmt_cls,
  output logic [KEEP_W-1:0]             cmt_addr,
  output logic [NSLOT-1:0][WORD_W-1:0]  slot
);

  seq_st_e                      st_q, st_d;
  logic [2:0]                   cnt_q, cnt_d;
  logic [3:0]                   need_q, need_d;
  logic [CLS_W-1:0]             cls_q, cls_d;
  logic [KEEP_W-1:0]            addr_q, addr_d;
  logic                         ldp_q, ldp_d;
  logic [NSLOT-1:0][WORD_W-1:0] stage_q;
  logic                         data_take;
  logic                         last;
  logic [3:0]                   hdr_need;

  // next-state logic
  always_comb begin
    hdr_need  = words_for(din[WORD_W-1 -: CLS_W]);
    hdr_take  = (st_q == ST_IDLE) && !pause && ldp_q && !ld_n;
    data_take = (st_q == ST_DATA) && !pause;
    last      = data_take && ({1'b0, cnt_q} == (need_q - 4'd1));
    st_d   = st_q;
    cnt_d  = cnt_q;
    need_d = need_q;
    cls_d  = cls_q;
    addr_d = addr_q;
    // strobe history only advances on unpaused cycles
    ldp_d  = pause ? ldp_q : ld_n;
    if (hdr_take) begin
      cls_d  = din[WORD_W-1 -: CLS_W];
      addr_d = din[KEEP_W-1:0];
      need_d = hdr_need;
      cnt_d  = 3'd0;
      if (hdr_need != 4'd0) st_d = ST_DATA;
    end else if (data_take) begin
      if (last) begin
        st_d  = ST_IDLE;
        cnt_d = 3'd0;
      end else begin
        cnt_d = cnt_q + 3'd1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      need_q <= '0;
      cls_q  <= '0;
      addr_q <= '0;
      ldp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      need_q <= need_d;
      cls_q  <= cls_d;
      addr_q <= addr_d;
      ldp_q  <= ldp_d;
    end
  end

  // staging slots; the word arriving this cycle bypasses into its slot
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic slot_en;
    assign slot_en = data_take && (cnt_q == 3'(g));
    assign slot[g] = slot_en ? din : stage_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stage_q[g] <= '0;
      else if (slot_en) stage_q[g] <= din;
    end
  end

  assign busy     = (st_q == ST_DATA);
  assign commit   = last;
  assign cmt_cls  = cls_q;
  assign cmt_addr = addr_q;

endmodule

// File: rtl/filt_ld_coef.sv
module filt_ld_coef #(
  parameter int BANKS = 8,
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = $clog2(BANKS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [BANKS-1:0][W-1:0]  wdata,
  input  logic [BW-1:0]            rbank,
  input  logic [AW-1:0]            raddr,
  output logic [W-1:0]             rdata
);

  logic [BANKS-1:0][DEPTH-1:0][W-1:0] mem_q;

  // all banks take their word on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (we) begin
      for (int b = 0; b < BANKS; b++) mem_q[b][waddr] <= wdata[b];
    end
  end

  assign rdata = mem_q[rbank][raddr];

endmodule

// File: rtl/filt_ld_regs.sv
module filt_ld_regs #(
  parameter int N  = 16,
  parameter int W  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ridx,
  output logic [W-1:0]  rdata
);

  logic [N-1:0][W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  reg_q       <= '0;
    else if (we) reg_q[widx] <= wdata;
  end

  assign rdata = reg_q[ridx];

endmodule

// File: rtl/filt_cfg_loader.sv
module filt_cfg_loader
  import filt_ld_pkg::*;
#(
  parameter int COEF_DEPTH = 16,
  parameter int CFG_NUM    = 4,
  parameter int REG_NUM    = 16,
  parameter int REG_W      = 32,
  parameter int BYTE_W     = 8,
  localparam int COEF_AW   = $clog2(COEF_DEPTH),
  localparam int CFG_AW    = $clog2(CFG_NUM),
  localparam int REG_AW    = $clog2(REG_NUM),
  localparam int KEEP_W    = (COEF_AW > REG_AW) ? COEF_AW : REG_AW,
  localparam int NBYTE     = REG_W / BYTE_W,
  localparam int BANK_AW   = $clog2(NSLOT)
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               ld_n,
  input  logic               pause,
  input  logic [WORD_W-1:0]  din,
  input  logic [BANK_AW-1:0] coef_rd_bank,
  input  logic [COEF_AW-1:0] coef_rd_addr,
  output logic [WORD_W-1:0]  coef_rd_data,
  input  logic [CLS_W-1:0]   reg_rd_cls,
  input  logic [REG_AW-1:0]  reg_rd_idx,
  output logic [REG_W-1:0]   reg_rd_data
);

  logic [1:0]                   rsync_q;
  logic                         rst_n;
  logic                         busy;
  logic                         hdr_take;
  logic                         commit;
  logic [CLS_W-1:0]             cmt_cls;
  logic [KEEP_W-1:0]            cmt_addr;
  logic [NSLOT-1:0][WORD_W-1:0] slot;
  logic [REG_W-1:0]             wide_data;
  logic                         we_coef, we_cfg, we_sel, we_rnd, we_lim;
  logic [WORD_W-1:0]            cfg_rd, sel_rd;
  logic [REG_W-1:0]             rnd_rd, lim_rd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  filt_ld_seq #(.KEEP_W(KEEP_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_n     (ld_n),
    .pause    (pause),
    .din      (din),
    .busy     (busy),
    .hdr_take (hdr_take),
    .commit   (commit),
    .cmt_cls  (cmt_cls),
    .cmt_addr (cmt_addr),
    .slot     (slot)
  );

  // wide register assembled least significant byte first
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign wide_data[b*BYTE_W +: BYTE_W] = slot[b][BYTE_W-1:0];
  end

  always_comb begin
    we_coef = commit && (cmt_cls == CLS_COEF);
    we_cfg  = commit && (cmt_cls == CLS_CFG);
    we_sel  = commit && (cmt_cls == CLS_SEL);
    we_rnd  = commit && (cmt_cls == CLS_RND);
    we_lim  = commit && (cmt_cls == CLS_LIM);
  end

  filt_ld_coef #(.BANKS(NSLOT), .DEPTH(COEF_DEPTH), .W(WORD_W)) u_coef (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we_coef),
    .waddr (cmt_addr[COEF_AW-1:0]),
    .wdata (slot),
    .rbank (coef_rd_bank),
    .raddr (coef_rd_addr),
    .rdata (coef_rd_data)
  );

  filt_ld_regs #(.N(CFG_NUM), .W(WORD_W)) u_cfg (
    .clk (clk), .rst_n (rst_n), .we (we_cfg), .widx (cmt_addr[CFG_AW-1:0]),
    .wdata (slot[0]), .ridx (reg_rd_idx[CFG_AW-1:0]), .rdata (cfg_rd)
  );

  filt_ld_regs #(.N(REG_NUM), .W(WORD_W)) u_sel (
    .clk (clk), .rst_n (rst_n), .we (we_sel), .widx (cmt_addr[REG_AW-1:0]),
    .wdata (slot[0]), .ridx (reg_rd_idx), .rdata (sel_rd)
  );

  filt_ld_regs #(.N(REG_NUM), .W(REG_W)) u_rnd (
    .clk (clk), .rst_n (rst_n), .we (we_rnd), .widx (cmt_addr[REG_AW-1:0]),
    .wdata (wide_data), .ridx (reg_rd_idx), .rdata (rnd_rd)
  );

  filt_ld_regs #(.N(REG_NUM), .W(REG_W)) u_lim (
    .clk (clk), .rst_n (rst_n), .we (we_lim), .widx (cmt_addr[REG_AW-1:0]),
    .wdata (wide_data), .ridx (reg_rd_idx), .rdata (lim_rd)
  );

  always_comb begin
    case (reg_rd_cls)
      CLS_CFG: reg_rd_data = REG_W'(cfg_rd);
      CLS_SEL: reg_rd_data = REG_W'(sel_rd);
      CLS_RND: reg_rd_data = rnd_rd;
      CLS_LIM: reg_rd_data = lim_rd;
      default: reg_rd_data = '0;
    endcase
  end

endmodule

module filt_cfg_loader_chk
  import filt_ld_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ld_n,
  input logic              pause,
  input logic [WORD_W-1:0] din,
  input logic              busy,
  input logic              hdr_take,
  input logic              commit,
  input logic [4:0]        we_vec,
  input logic [CLS_W-1:0]  reg_rd_cls,
  input logic [3:0]        reg_rd_idx,
  input logic [31:0]       reg_rd_data
);

  assert_one_dest_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  assert_hdr_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take |-> (!ld_n && !pause && !busy));

  assert_pause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pause) |=> busy);

  assert_pause_no_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> (!hdr_take && !commit));

  assert_undef_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take && (words_for(din[WORD_W-1 -: CLS_W]) == 4'd0)) |=> !busy);

  assert_back_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(reg_rd_cls) && $stable(reg_rd_idx) && !$past(|we_vec[3:0]))
      |-> $stable(reg_rd_data));

endmodule

bind filt_cfg_loader filt_cfg_loader_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ld_n        (ld_n),
  .pause       (pause),
  .din         (din),
  .busy        (busy),
  .hdr_take    (hdr_take),
  .commit      (commit),
  .we_vec      ({we_coef, we_cfg, we_sel, we_rnd, we_lim}),
  .reg_rd_cls  (reg_rd_cls),
  .reg_rd_idx  (reg_rd_idx),
  .reg_rd_data (reg_rd_data)
);

// File: tb/filt_cfg_loader_bench.sv
module filt_cfg_loader_bench;

  localparam int CLKP = 20;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        ld_n;
  logic        pause;
  logic [11:0] din;
  logic [2:0]  coef_rd_bank;
  logic [3:0]  coef_rd_addr;
  logic [11:0] coef_rd_data;
  logic [2:0]  reg_rd_cls;
  logic [3:0]  reg_rd_idx;
  logic [31:0] reg_rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [11:0] m_coef [8][16];
  logic [11:0] m_cfg  [4];
  logic [11:0] m_sel  [16];
  logic [31:0] m_rnd  [16];
  logic [31:0] m_lim  [16];

  always #(CLKP/2) clk = ~clk;

  filt_cfg_loader u_filt_cfg_loader (
    .clk (clk), .arst_n (arst_n), .ld_n (ld_n), .pause (pause), .din (din),
    .coef_rd_bank (coef_rd_bank), .coef_rd_addr (coef_rd_addr),
    .coef_rd_data (coef_rd_data), .reg_rd_cls (reg_rd_cls),
    .reg_rd_idx (reg_rd_idx), .reg_rd_data (reg_rd_data)
  );

  function automatic int need_words(input logic [2:0] c);
    case (c)
      3'b000:         return 8;
      3'b001, 3'b011: return 1;
      3'b101, 3'b111: return 4;
      default:        return 0;
    endcase
  endfunction

  function automatic logic [31:0] pack4(input logic [11:0] w [8]);
    return {w[3][7:0], w[2][7:0], w[1][7:0], w[0][7:0]};
  endfunction

  task automatic apply_model(input logic [11:0] hdr, input logic [11:0] w [8]);
    case (hdr[11:9])
      3'b000: for (int b = 0; b < 8; b++) m_coef[b][hdr[3:0]] = w[b];
      3'b001: m_cfg[hdr[1:0]] = w[0];
      3'b011: m_sel[hdr[3:0]] = w[0];
      3'b101: m_rnd[hdr[3:0]] = pack4(w);
      3'b111: m_lim[hdr[3:0]] = pack4(w);
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd_coef(input int b, input int a, output logic [11:0] v);
    coef_rd_bank = 3'(b);
    coef_rd_addr = 4'(a);
    #1 v = coef_rd_data;
  endtask

  task automatic rd_reg(input logic [2:0] c, input int i, output logic [31:0] v);
    reg_rd_cls = c;
    reg_rd_idx = 4'(i);
    #1 v = reg_rd_data;
  endtask

  task automatic rand_pause(input int pp);
    while (int'($urandom_range(99)) < pp) begin
      pause = 1'b1;
      din   = 12'($urandom);
      step();
    end
    pause = 1'b0;
  endtask

  // one complete transfer with random stalls; model updated afterwards
  task automatic send(input logic [11:0] hdr, input logic [11:0] w [8], input int pp);
    ld_n = 1'b1; pause = 1'b0; din = 12'($urandom);
    step();
    rand_pause(pp);
    ld_n = 1'b0; din = hdr;
    step();
    for (int i = 0; i < need_words(hdr[11:9]); i++) begin
      rand_pause(pp);
      din = w[i];
      step();
    end
    ld_n = 1'b1;
    apply_model(hdr, w);
  endtask

  task automatic sweep();
    logic [11:0] c;
    logic [31:0] r;
    for (int b = 0; b < 8; b++)
      for (int a = 0; a < 16; a++) begin
        rd_coef(b, a, c);
        chk("R3", $sformatf("coef b%0d a%0d", b, a), 32'(c), 32'(m_coef[b][a]));
      end
    for (int i = 0; i < 4; i++) begin
      rd_reg(3'b001, i, r); chk("R4", $sformatf("cfg %0d", i), r, 32'(m_cfg[i]));
    end
    for (int i = 0; i < 16; i++) begin
      rd_reg(3'b011, i, r); chk("R4", $sformatf("sel %0d", i), r, 32'(m_sel[i]));
      rd_reg(3'b101, i, r); chk("R5", $sformatf("rnd %0d", i), r, m_rnd[i]);
      rd_reg(3'b111, i, r); chk("R5", $sformatf("lim %0d", i), r, m_lim[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] w [8];
    logic [11:0] c;
    logic [31:0] r;
    logic [11:0] hdr;
    void'($urandom(32'd1207));
    for (int b = 0; b < 8; b++) for (int a = 0; a < 16; a++) m_coef[b][a] = '0;
    for (int i = 0; i < 4; i++) m_cfg[i] = '0;
    for (int i = 0; i < 16; i++) begin m_sel[i] = '0; m_rnd[i] = '0; m_lim[i] = '0; end
    arst_n = 1'b0; ld_n = 1'b1; pause = 1'b0; din = '0;
    coef_rd_bank = '0; coef_rd_addr = '0; reg_rd_cls = '0; reg_rd_idx = '0;
    step(); step(); step();
    arst_n = 1'b1;
    repeat (4) step();

    // R11: everything reads zero after reset
    rd_coef(7, 15, c); chk("R11", "coef after reset", 32'(c), 32'h0);
    rd_reg(3'b111, 15, r); chk("R11", "lim after reset", r, 32'h0);
    rd_reg(3'b001, 0, r);  chk("R11", "cfg after reset", r, 32'h0);

    // R3: coefficient header for entry 15
    w = '{12'h210, 12'h543, 12'hC76, 12'h9E3, 12'h701, 12'h832, 12'hF20, 12'h143};
    send(12'h00F, w, 0);
    for (int b = 0; b < 8; b++) begin
      rd_coef(b, 15, c); chk("R3", $sformatf("bank %0d", b), 32'(c), 32'(w[b]));
    end

    // R5: limit 10 with reserved nibbles set, which must be ignored
    w = '{12'hF12, 12'hA34, 12'h556, 12'h378, 12'h0, 12'h0, 12'h0, 12'h0};
    send(12'hE0A, w, 0);
    rd_reg(3'b111, 10, r); chk("R5", "limit 10 bytes", r, 32'h78563412);

    // R9: partial round load stays invisible until the fourth word
    ld_n = 1'b1; step();
    ld_n = 1'b0; din = 12'hA03; step();
    din = 12'h0AA; step();
    din = 12'h0BB; step();
    din = 12'h0CC; step();
    pause = 1'b1; din = 12'h0EE; step(); step();
    rd_reg(3'b101, 3, r); chk("R9", "round 3 before last word", r, 32'h0);
    pause = 1'b0; din = 12'h0DD; step();
    rd_reg(3'b101, 3, r); chk("R9", "round 3 after last word", r, 32'hDDCCBBAA);
    m_rnd[3] = 32'hDDCCBBAA;
    ld_n = 1'b1;

    // R6: long stall with junk on din before the only data word
    ld_n = 1'b1; step();
    ld_n = 1'b0; din = 12'h607; step();
    pause = 1'b1;
    for (int i = 0; i < 5; i++) begin din = 12'h777; step(); end
    pause = 1'b0; din = 12'h5A5; step();
    m_sel[7] = 12'h5A5;
    rd_reg(3'b011, 7, r); chk("R6", "select 7 after stall", r, 32'h5A5);

    // R2 R8: strobe held low after a transfer; header-like words are not taken
    w = '{12'h0C3, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0};
    send(12'h201, w, 0);
    ld_n = 1'b0; din = 12'h605; step();
    din = 12'h0AB; step(); step();
    ld_n = 1'b1;
    rd_reg(3'b011, 5, r); chk("R2 R8", "select 5 untouched", r, 32'h0);
    rd_reg(3'b001, 1, r); chk("R4", "cfg 1", r, 32'h0C3);

    // R7: undefined code, then words that would be a select header and data
    ld_n = 1'b1; step();
    ld_n = 1'b0; din = 12'h409; step();
    din = 12'h609; step();
    din = 12'h123; step();
    ld_n = 1'b1;
    rd_reg(3'b011, 9, r); chk("R7", "select 9 untouched", r, 32'h0);
    w = '{12'h3C3, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0};
    send(12'h609, w, 0);
    rd_reg(3'b011, 9, r); chk("R7", "select 9 after recovery", r, 32'h3C3);

    // R10: undefined readback class reads zero
    rd_reg(3'b010, 3, r); chk("R10", "readback code 010", r, 32'h0);
    rd_reg(3'b100, 10, r); chk("R10", "readback code 100", r, 32'h0);

    // R1: random traffic over all class codes with random stalls
    for (int n = 0; n < 120; n++) begin
      hdr = 12'($urandom);
      for (int k = 0; k < 8; k++) w[k] = 12'($urandom);
      send(hdr, w, 30);
    end
    sweep();
    rd_reg(3'b110, 0, r); chk("R1", "code 110 writes nothing readable", r, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule